// File: doc/BRIEF.md
# Rendezvous Receive Matcher

This block is the receiving side of a three-phase message handshake. Software, or a neighbouring controller, posts receives into a four-entry table. Each posted receive gives the expected sender node, a message tag, a local buffer base address and a buffer length in words. Senders do not push payload first. They announce themselves with a send-ready request that carries their node, tag and message length. When that request finds a waiting posted receive with the same node and tag, the block answers with a reply on its handshake output. The reply carries the local buffer address and the granted length, so the sender learns where its data lands. From then on, data packets tagged with that node and tag are written word by word into the buffer through a plain address/data write port.

A send-ready request that finds no waiting receive is parked in a four-entry pending table, and the sender is free to continue. A receive posted later that matches a parked request is activated at once. The block then emits a request on the same handshake output, asking that sender to push its data. Whenever several entries match, the oldest one wins. A receive completes when the number of words written reaches the granted length. At that point its entry is released and a completion pulse carries the tag. A data packet that belongs to no active transfer is discarded and flagged.

Top module: `rdv_match_engine`

## Requirements
- R1: A posted receive is taken only when a posted-receive entry is free and `sr_valid` is low in the same cycle. `post_busy` is high whenever all 4 entries are in use or `sr_valid` is high, and a refused post changes no table state.
- R2: A send-ready request whose node and tag equal those of a waiting (not yet activated) posted receive produces, one cycle later, `rr_valid`=1 with `rr_kind`=0. The same reply carries `rr_node` equal to the requester node, the request tag, the posted buffer address, and an `rr_len` that is the smaller of the posted and announced lengths.
- R3: A send-ready request that matches no waiting receive is stored as pending and produces no reply. If the pending table already holds 4 entries, `sr_busy` is high in that cycle and the request is discarded.
- R4: A post that is taken and matches a pending request produces, one cycle later, `rr_valid`=1 with `rr_kind`=1. That request carries `rr_node` equal to the parked sender, the tag, the new buffer address and the smaller of the two lengths, and the pending entry is consumed.
- R5: When several posted receives (or pending requests) match, the one stored earliest is chosen.
- R6: A data packet whose node and tag match an activated receive gives `wr_en`=1 one cycle later. `wr_addr` is the buffer base plus the number of words already written, and `wr_data` is the packet word.
- R7: A data packet that matches no activated receive, including one that is posted but still waiting, gives `dx_err`=1 one cycle later and no write.
- R8: The write that brings the word count to the granted length comes with `done_valid`=1 and `done_tag` equal to the tag, and it frees the entry. Later packets with that tag are flagged as errors.
- R9: No write occurs for a receive until it has been activated by a reply (R2) or a request (R4).
- R10: After reset both tables are empty and `rr_valid`, `wr_en`, `done_valid` and `dx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Post a receive this cycle |
| post_src | input | SRC_W | Expected sender node |
| post_tag | input | TAG_W | Expected message tag |
| post_addr | input | ADDR_W | Local buffer base address |
| post_len | input | LEN_W | Buffer length in words (nonzero) |
| post_busy | output | 1 | Post cannot be taken this cycle |
| sr_valid | input | 1 | Send-ready request this cycle |
| sr_src | input | SRC_W | Requesting node |
| sr_tag | input | TAG_W | Message tag |
| sr_len | input | LEN_W | Announced message length (nonzero) |
| sr_busy | output | 1 | Unmatched request discarded, pending table full |
| dx_valid | input | 1 | Data word arriving this cycle |
| dx_src | input | SRC_W | Node the word comes from |
| dx_tag | input | TAG_W | Tag of the word |
| dx_data | input | DATA_W | Payload word |
| rr_valid | output | 1 | Handshake message out |
| rr_kind | output | 1 | 0: reply to send-ready, 1: request after late post |
| rr_node | output | SRC_W | Node the handshake goes to |
| rr_tag | output | TAG_W | Tag of the handshake |
| rr_addr | output | ADDR_W | Local buffer base address |
| rr_len | output | LEN_W | Granted length |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | DATA_W | Memory write data |
| done_valid | output | 1 | Receive complete pulse |
| done_tag | output | TAG_W | Tag of the completed receive |
| dx_err | output | 1 | Data word discarded, no active transfer |

## Verification
On every cycle the assertions check that each handshake message and each write traces back to an input from the previous cycle with the same node, tag or data. They also check that a completion pulse only ever rides on a write, that a discarded word never writes, and that the busy outputs only rise under their stated causes. The rest can only be shown by the bench's scenarios: which table entry wins a multi-way match by age, that the write address advances through the buffer, that the granted length is the smaller of the two lengths, and that a refused post or a dropped send-ready leaves no trace.

// File: rtl/rdv_match_engine.sv
module rdv_match_engine #(
  parameter int DEPTH  = 4,
  parameter int SRC_W  = 4,
  parameter int TAG_W  = 8,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_valid,
  input  logic [SRC_W-1:0]  post_src,
  input  logic [TAG_W-1:0]  post_tag,
  input  logic [ADDR_W-1:0] post_addr,
  input  logic [LEN_W-1:0]  post_len,
  output logic              post_busy,
  input  logic              sr_valid,
  input  logic [SRC_W-1:0]  sr_src,
  input  logic [TAG_W-1:0]  sr_tag,
  input  logic [LEN_W-1:0]  sr_len,
  output logic              sr_busy,
  input  logic              dx_valid,
  input  logic [SRC_W-1:0]  dx_src,
  input  logic [TAG_W-1:0]  dx_tag,
  input  logic [DATA_W-1:0] dx_data,
  output logic              rr_valid,
  output logic              rr_kind,
  output logic [SRC_W-1:0]  rr_node,
  output logic [TAG_W-1:0]  rr_tag,
  output logic [ADDR_W-1:0] rr_addr,
  output logic [LEN_W-1:0]  rr_len,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag,
  output logic              dx_err
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // posted-receive table; rcv_old[i][j] set means entry j was stored before entry i
  logic [DEPTH-1:0]             rcv_val, rcv_act;
  logic [SRC_W-1:0]             rcv_src  [DEPTH];
  logic [TAG_W-1:0]             rcv_tag  [DEPTH];
  logic [ADDR_W-1:0]            rcv_addr [DEPTH];
  logic [LEN_W-1:0]             rcv_len  [DEPTH];
  logic [LEN_W-1:0]             rcv_cnt  [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0]  rcv_old;

  // pending send-ready table
  logic [DEPTH-1:0]             pnd_val;
  logic [SRC_W-1:0]             pnd_src [DEPTH];
  logic [TAG_W-1:0]             pnd_tag [DEPTH];
  logic [LEN_W-1:0]             pnd_len [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0]  pnd_old;

  function automatic logic [DEPTH-1:0] pick_oldest(input logic [DEPTH-1:0] hit,
                                                   input logic [DEPTH-1:0][DEPTH-1:0] old);
    logic [DEPTH-1:0] sel;
    for (int i = 0; i < DEPTH; i++) sel[i] = hit[i] & ~|(hit & old[i]);
    return sel;
  endfunction

  function automatic logic [IDX_W-1:0] to_index(input logic [DEPTH-1:0] oh);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < DEPTH; i++) if (oh[i]) idx = IDX_W'(i);
    return idx;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_free(input logic [DEPTH-1:0] used);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (!used[i]) idx = IDX_W'(i);
    return idx;
  endfunction

  function automatic logic [LEN_W-1:0] smaller(input logic [LEN_W-1:0] a, input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [DEPTH-1:0] sr_hit, dx_hit, post_hit;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      sr_hit[i]   = rcv_val[i] & ~rcv_act[i] & (rcv_src[i] == sr_src)   & (rcv_tag[i] == sr_tag);
      dx_hit[i]   = rcv_val[i] &  rcv_act[i] & (rcv_src[i] == dx_src)   & (rcv_tag[i] == dx_tag);
      post_hit[i] = pnd_val[i] &               (pnd_src[i] == post_src) & (pnd_tag[i] == post_tag);
    end
  end

  logic [IDX_W-1:0] sr_i, dx_i, pnd_i, rcv_free, pnd_free;
  assign sr_i     = to_index(pick_oldest(sr_hit, rcv_old));
  assign dx_i     = to_index(pick_oldest(dx_hit, rcv_old));
  assign pnd_i    = to_index(pick_oldest(post_hit, pnd_old));
  assign rcv_free = lowest_free(rcv_val);
  assign pnd_free = lowest_free(pnd_val);

  logic post_match, post_take, sr_match, sr_go, sr_store, dx_go, dx_last;
  assign post_busy  = sr_valid | (&rcv_val);
  assign post_match = |post_hit;
  assign post_take  = post_valid & ~post_busy;
  assign sr_match   = |sr_hit;
  assign sr_go      = sr_valid & sr_match;
  assign sr_store   = sr_valid & ~sr_match & ~(&pnd_val);
  assign sr_busy    = sr_valid & ~sr_match & (&pnd_val);
  assign dx_go      = dx_valid & (|dx_hit);
  assign dx_last    = dx_go & ((rcv_cnt[dx_i] + LEN_W'(1)) == rcv_len[dx_i]);

  logic [LEN_W-1:0] sr_grant, post_grant;
  assign sr_grant   = smaller(rcv_len[sr_i], sr_len);
  assign post_grant = smaller(post_len, pnd_len[pnd_i]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcv_val    <= '0;
      rcv_act    <= '0;
      rcv_old    <= '0;
      pnd_val    <= '0;
      pnd_old    <= '0;
      rr_valid   <= 1'b0;
      rr_kind    <= 1'b0;
      rr_node    <= '0;
      rr_tag     <= '0;
      rr_addr    <= '0;
      rr_len     <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done_valid <= 1'b0;
      done_tag   <= '0;
      dx_err     <= 1'b0;
    end else begin
      if (dx_go) begin
        rcv_cnt[dx_i] <= rcv_cnt[dx_i] + LEN_W'(1);
        if (dx_last) rcv_val[dx_i] <= 1'b0;
      end

      if (sr_go) begin
        rcv_act[sr_i] <= 1'b1;
        rcv_len[sr_i] <= sr_grant;
      end

      if (post_take) begin
        rcv_val[rcv_free]  <= 1'b1;
        rcv_act[rcv_free]  <= post_match;
        rcv_src[rcv_free]  <= post_src;
        rcv_tag[rcv_free]  <= post_tag;
        rcv_addr[rcv_free] <= post_addr;
        rcv_len[rcv_free]  <= post_match ? post_grant : post_len;
        rcv_cnt[rcv_free]  <= '0;
        for (int k = 0; k < DEPTH; k++) rcv_old[k][rcv_free] <= 1'b0;
        rcv_old[rcv_free] <= rcv_val;
        if (post_match) pnd_val[pnd_i] <= 1'b0;
      end

      if (sr_store) begin
        pnd_val[pnd_free] <= 1'b1;
        pnd_src[pnd_free] <= sr_src;
        pnd_tag[pnd_free] <= sr_tag;
        pnd_len[pnd_free] <= sr_len;
        for (int k = 0; k < DEPTH; k++) pnd_old[k][pnd_free] <= 1'b0;
        pnd_old[pnd_free] <= pnd_val;
      end

      rr_valid <= sr_go | (post_take & post_match);
      if (sr_go) begin
        rr_kind <= 1'b0;
        rr_node <= sr_src;
        rr_tag  <= sr_tag;
        rr_addr <= rcv_addr[sr_i];
        rr_len  <= sr_grant;
      end else if (post_take & post_match) begin
        rr_kind <= 1'b1;
        rr_node <= post_src;
        rr_tag  <= post_tag;
        rr_addr <= post_addr;
        rr_len  <= post_grant;
      end

      wr_en      <= dx_go;
      wr_addr    <= rcv_addr[dx_i] + ADDR_W'(rcv_cnt[dx_i]);
      wr_data    <= dx_data;
      done_valid <= dx_last;
      done_tag   <= dx_tag;
      dx_err     <= dx_valid & ~(|dx_hit);
    end
  end

endmodule

// File: rtl/rdv_match_engine_chk.sv
module rdv_match_engine_chk #(
  parameter int SRC_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              post_valid,
  input logic [SRC_W-1:0]  post_src,
  input logic [TAG_W-1:0]  post_tag,
  input logic              post_busy,
  input logic              sr_valid,
  input logic [SRC_W-1:0]  sr_src,
  input logic [TAG_W-1:0]  sr_tag,
  input logic              sr_busy,
  input logic              dx_valid,
  input logic [DATA_W-1:0] dx_data,
  input logic              rr_valid,
  input logic              rr_kind,
  input logic [SRC_W-1:0]  rr_node,
  input logic [TAG_W-1:0]  rr_tag,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              done_valid,
  input logic              dx_err
);

  assert_busy_on_sr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sr_valid |-> post_busy);

  assert_reply_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && !rr_kind) |-> ($past(sr_valid) && rr_node == $past(sr_src) && rr_tag == $past(sr_tag)));

  assert_sr_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_busy |-> sr_valid);

  assert_request_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_valid && rr_kind) |-> ($past(post_valid && !post_busy) && rr_node == $past(post_src)
                               && rr_tag == $past(post_tag)));

  assert_write_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(dx_valid) && wr_data == $past(dx_data)));

  assert_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dx_err |-> (!wr_en && $past(dx_valid)));

  assert_done_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> wr_en);

endmodule

bind rdv_match_engine rdv_match_engine_chk #(.SRC_W(SRC_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/rdv_match_engine_tb.sv
module rdv_match_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_valid = 1'b0, sr_valid = 1'b0, dx_valid = 1'b0;
  logic [3:0]  post_src = '0, sr_src = '0, dx_src = '0;
  logic [7:0]  post_tag = '0, sr_tag = '0, dx_tag = '0;
  logic [15:0] post_addr = '0;
  logic [7:0]  post_len = '0, sr_len = '0;
  logic [31:0] dx_data = '0;
  logic        post_busy, sr_busy, rr_valid, rr_kind, wr_en, done_valid, dx_err;
  logic [3:0]  rr_node;
  logic [7:0]  rr_tag, rr_len, done_tag;
  logic [15:0] rr_addr, wr_addr;
  logic [31:0] wr_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  rdv_match_engine u_dut (
    .clk, .rst_n,
    .post_valid, .post_src, .post_tag, .post_addr, .post_len, .post_busy,
    .sr_valid, .sr_src, .sr_tag, .sr_len, .sr_busy,
    .dx_valid, .dx_src, .dx_tag, .dx_data,
    .rr_valid, .rr_kind, .rr_node, .rr_tag, .rr_addr, .rr_len,
    .wr_en, .wr_addr, .wr_data, .done_valid, .done_tag, .dx_err
  );

  typedef struct packed {
    logic [1:0]  op;     // 0 post, 1 send-ready, 2 data
    logic [3:0]  src;
    logic [7:0]  tag;
    logic [15:0] val;    // buffer address or data word
    logic [7:0]  len;
    logic        e_rr;
    logic        e_kind;
    logic        e_wr;
    logic        e_done;
    logic        e_err;
    logic [15:0] e_addr; // rr_addr or wr_addr
    logic [7:0]  e_len;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd3, 8'h11, 16'h0100, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd0},
    '{2'd1, 4'd3, 8'h11, 16'h0000, 8'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0100, 8'd3},
    '{2'd2, 4'd3, 8'h11, 16'hAAA1, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0100, 8'd0},
    '{2'd2, 4'd3, 8'h22, 16'hBAD0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'd0},
    '{2'd2, 4'd3, 8'h11, 16'hAAA2, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0101, 8'd0},
    '{2'd2, 4'd3, 8'h11, 16'hAAA3, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0102, 8'd0},
    '{2'd2, 4'd3, 8'h11, 16'hAAA4, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'd0},
    '{2'd1, 4'd5, 8'h33, 16'h0000, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd0},
    '{2'd0, 4'd5, 8'h33, 16'h0200, 8'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0200, 8'd2},
    '{2'd2, 4'd5, 8'h33, 16'hC001, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0200, 8'd0},
    '{2'd2, 4'd5, 8'h33, 16'hC002, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0201, 8'd0},
    '{2'd0, 4'd1, 8'h44, 16'h0300, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd0},
    '{2'd2, 4'd1, 8'h44, 16'hD000, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'd0},
    '{2'd0, 4'd1, 8'h44, 16'h0400, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd0},
    '{2'd1, 4'd1, 8'h44, 16'h0000, 8'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0300, 8'd2},
    '{2'd1, 4'd1, 8'h44, 16'h0000, 8'd9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0400, 8'd1},
    '{2'd2, 4'd1, 8'h44, 16'hE001, 8'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0300, 8'd0},
    '{2'd2, 4'd1, 8'h44, 16'hE002, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0301, 8'd0},
    '{2'd2, 4'd1, 8'h44, 16'hE003, 8'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0400, 8'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [3:0] s, input logic [7:0] t,
                       input logic [15:0] v, input logic [7:0] l);
    @(negedge clk);
    case (op)
      2'd0: begin post_valid = 1'b1; post_src = s; post_tag = t; post_addr = v; post_len = l; end
      2'd1: begin sr_valid = 1'b1; sr_src = s; sr_tag = t; sr_len = l; end
      default: begin dx_valid = 1'b1; dx_src = s; dx_tag = t; dx_data = {16'hC0DE, v}; end
    endcase
    #1;
  endtask

  task automatic settle;
    @(posedge clk);
    #1;
    post_valid = 1'b0;
    sr_valid   = 1'b0;
    dx_valid   = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    post_valid = 1'b0; sr_valid = 1'b0; dx_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R10: reset state
    chk("R10 rr_valid", 32'(rr_valid), 32'd0);
    chk("R10 wr_en", 32'(wr_en), 32'd0);
    chk("R10 done_valid", 32'(done_valid), 32'd0);
    chk("R10 dx_err", 32'(dx_err), 32'd0);
    chk("R10 post_busy empty table", 32'(post_busy), 32'd0);

    // table walk: R2 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].src, VEC[i].tag, VEC[i].val, VEC[i].len);
      settle();
      chk($sformatf("R2/R4 rr_valid v%0d", i), 32'(rr_valid), 32'(VEC[i].e_rr));
      if (VEC[i].e_rr) begin
        chk($sformatf("R2/R4 rr_kind v%0d", i), 32'(rr_kind), 32'(VEC[i].e_kind));
        chk($sformatf("R2/R4 rr_node v%0d", i), 32'(rr_node), 32'(VEC[i].src));
        chk($sformatf("R5 rr_addr v%0d", i), 32'(rr_addr), 32'(VEC[i].e_addr));
        chk($sformatf("R2/R4 rr_len v%0d", i), 32'(rr_len), 32'(VEC[i].e_len));
      end
      chk($sformatf("R6/R9 wr_en v%0d", i), 32'(wr_en), 32'(VEC[i].e_wr));
      if (VEC[i].e_wr) begin
        chk($sformatf("R6 wr_addr v%0d", i), 32'(wr_addr), 32'(VEC[i].e_addr));
        chk($sformatf("R6 wr_data v%0d", i), wr_data, {16'hC0DE, VEC[i].val});
      end
      chk($sformatf("R8 done_valid v%0d", i), 32'(done_valid), 32'(VEC[i].e_done));
      if (VEC[i].e_done) chk($sformatf("R8 done_tag v%0d", i), 32'(done_tag), 32'(VEC[i].tag));
      chk($sformatf("R7 dx_err v%0d", i), 32'(dx_err), 32'(VEC[i].e_err));
    end

    // R1: full posted table refuses, refused post leaves nothing behind
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      drive(2'd0, 4'd0, 8'(k), 16'(16'h1000 + k), 8'd1);
      chk("R1 post_busy while filling", 32'(post_busy), 32'd0);
      settle();
    end
    drive(2'd0, 4'd0, 8'd5, 16'h1005, 8'd1);
    chk("R1 post_busy table full", 32'(post_busy), 32'd1);
    settle();
    drive(2'd1, 4'd0, 8'd5, 16'h0, 8'd1);
    settle();
    chk("R1 refused post made no entry", 32'(rr_valid), 32'd0);
    drive(2'd1, 4'd0, 8'd2, 16'h0, 8'd1);
    settle();
    chk("R1 held entry still replies", 32'(rr_valid), 32'd1);
    chk("R1 held entry address", 32'(rr_addr), 32'h1002);

    // R1: send-ready in the same cycle refuses the post
    do_reset();
    @(negedge clk);
    post_valid = 1'b1; post_src = 4'd7; post_tag = 8'h70; post_addr = 16'h7000; post_len = 8'd1;
    sr_valid = 1'b1; sr_src = 4'd8; sr_tag = 8'h80; sr_len = 8'd1;
    #1;
    chk("R1 post_busy with sr_valid", 32'(post_busy), 32'd1);
    settle();
    drive(2'd1, 4'd7, 8'h70, 16'h0, 8'd1);
    settle();
    chk("R1 post refused by send-ready", 32'(rr_valid), 32'd0);

    // R3 R4 R5: pending table fill, overflow drop, oldest pending wins
    do_reset();
    drive(2'd1, 4'd2, 8'h01, 16'h0, 8'd2); settle();
    chk("R3 unmatched sr gives no reply", 32'(rr_valid), 32'd0);
    drive(2'd1, 4'd2, 8'h01, 16'h0, 8'd3); settle();
    drive(2'd1, 4'd2, 8'h02, 16'h0, 8'd1); settle();
    drive(2'd1, 4'd2, 8'h03, 16'h0, 8'd1); settle();
    drive(2'd1, 4'd2, 8'h09, 16'h0, 8'd1);
    chk("R3 sr_busy pending full", 32'(sr_busy), 32'd1);
    settle();
    drive(2'd0, 4'd2, 8'h09, 16'h0900, 8'd1); settle();
    chk("R3 dropped sr left no pending", 32'(rr_valid), 32'd0);
    drive(2'd0, 4'd2, 8'h01, 16'h0500, 8'd9); settle();
    chk("R4 late post request", 32'(rr_valid), 32'd1);
    chk("R4 request kind", 32'(rr_kind), 32'd1);
    chk("R5 oldest pending length", 32'(rr_len), 32'd2);
    drive(2'd0, 4'd2, 8'h01, 16'h0600, 8'd9); settle();
    chk("R5 second pending length", 32'(rr_len), 32'd3);
    chk("R4 second request address", 32'(rr_addr), 32'h0600);
    drive(2'd1, 4'd2, 8'h09, 16'h0, 8'd1);
    chk("R3 sr_busy clear after consume", 32'(sr_busy), 32'd0);
    settle();
    chk("R2 waiting post now matched", 32'(rr_valid), 32'd1);
    chk("R2 reply kind", 32'(rr_kind), 32'd0);
    chk("R2 reply address", 32'(rr_addr), 32'h0900);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule